// File: doc/BRIEF.md
# Tile Prefetch Overlap Scheduler

This block schedules the off-chip traffic of a tiled matrix contraction running out of a scratch-pad that holds one N×N tile each of the left operand (A), the right operand (B) and the result (C). The output is covered by T1×T3 result tiles. Each result tile accumulates over T2 operand tile pairs. The scheduler walks that loop nest by following the compute sequencer's one-pulse-per-finished-entry progress signal. As soon as the compute side has finished with an A row or a B column, the scheduler requests the matching row or column of the next operand tile. The next tile is therefore loaded piecewise into storage the current tile has just vacated, and the switch between tile pairs does not stall.

Rows of A become free one at a time as the output rows complete. Columns of B become free one by one during the last output row, after each of its entries. The last row and the last column are freed by the final entry of the pair. After the last pair of a result tile, every C row is written back. The write-back burst also clears the row, so zeroing the new tile costs nothing extra. The compute side is told, through a registered go signal, whether the operands and the accumulator row of its current entry are in place.

One burst is outstanding at a time. When several slots are pending, C write-backs are served first, then A rows, then B columns, and the lowest index wins within a kind. Every burst moves N words, so the total traffic equals the non-overlapped count. The scheduler changes only when the bursts happen.

Top module: `tile_prefetch_sched`

## Requirements
- R1: After reset, burst_req, may_compute, fill_vld and done are all low.
- R2: A burst request carries burst_kind 0 for an A row load, 1 for a B column load or 2 for a C row write-back. Kind and index stay unchanged while burst_req is high and burst_ack is low. burst_req is low in the cycle after the acknowledge.
- R3: The load of A row r for the next tile pair is requested only after the entry in row r, column N-1 of the current pair has completed. No A row is reloaded after the final pair of the run.
- R4: The load of B column c for the next pair is requested only after the entry in row N-1, column c of the current pair has completed. No B column is reloaded after the final pair.
- R5: The completion of the last entry of the last pair of a result tile makes every C row due for write-back. A C row write-back is never requested at any other time, and the row counts as cleared only after its acknowledge.
- R6: In every cycle of a run, may_compute is high exactly when three things hold for the current entry (r,c): A row r holds the current pair's data, B column c holds the current pair's data, and C row r is not waiting for write-back. It is low when no run is active.
- R7: A run with tile counts T1,T2,T3 issues exactly N·T1·T2·T3 A row loads, the same number of B column loads, and N·T1·T3 C row write-backs.
- R8: In the cycle after each acknowledged burst, fill_vld pulses with that burst's kind and index on fill_kind and fill_idx.
- R9: Consider a tile-pair boundary inside a result tile, with earlier loads acknowledged in time. may_compute is high in the cycle right after the last entry of the pair completes.
- R10: done rises once the final entry is complete and all write-backs have been acknowledged. It stays high until the next accepted start and is cleared by it. While done is high, burst_req and may_compute are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; taken only while idle with no traffic left |
| cfg_t1 | input | CW | Result tile rows T1, sampled at start |
| cfg_t2 | input | CW | Operand pairs per result tile T2, sampled at start |
| cfg_t3 | input | CW | Result tile columns T3, sampled at start |
| entry_done | input | 1 | One-cycle pulse: compute finished the current output entry |
| may_compute | output | 1 | Operands and accumulator row of the current entry are ready |
| burst_req | output | 1 | Off-chip burst request, held until acknowledged |
| burst_kind | output | 2 | 0 A row load, 1 B column load, 2 C row write-back |
| burst_idx | output | $clog2(N) | Row or column index of the burst |
| burst_ack | input | 1 | One-cycle pulse: current burst completed |
| fill_vld | output | 1 | Pulse: a slot has just been refilled or written back |
| fill_kind | output | 2 | Kind of the completed burst |
| fill_idx | output | $clog2(N) | Index of the completed burst |
| done | output | 1 | Run complete and all traffic drained |

## Verification
A lost release or a doubly set slot shows up as a burst whose index has not yet been freed, or as a run whose burst totals differ from the non-overlapped counts. The first of these is visible as soon as the burst is requested. A wrong valid bit or a stale walker position shows up in the same cycle as a may_compute value that disagrees with which rows and columns have actually been refilled. The bench also stretches memory latency, and it keeps compute slow enough that prefetching should win. Under those conditions a lost overlap shows up as may_compute low in the cycle after a tile-pair boundary.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    KIND_AROW = 2'd0,
    KIND_BCOL = 2'd1,
    KIND_CWB  = 2'd2
  } burst_kind_e;
endpackage

// File: rtl/tps_walker.sv
// Follows the compute position through entries, tile pairs and result tiles.
module tps_walker #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int RW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [CW-1:0] cfg_t1,
  input  logic [CW-1:0] cfg_t2,
  input  logic [CW-1:0] cfg_t3,
  input  logic          entry_done,
  output logic [RW-1:0] row,
  output logic [RW-1:0] col,
  output logic [RW-1:0] row_nxt,
  output logic [RW-1:0] col_nxt,
  output logic          row_fin,
  output logic          col_fin,
  output logic          step_end,
  output logic          otile_end,
  output logic          last_step
);
  localparam logic [RW-1:0] LASTI = RW'(N - 1);

  logic [CW-1:0] k1, k2, k3;
  logic [CW-1:0] t, t1, t3;
  logic          t_wrap, t3_wrap;

  assign t_wrap    = (t  == k2 - CW'(1));
  assign t3_wrap   = (t3 == k3 - CW'(1));
  assign row_fin   = entry_done && (col == LASTI);
  assign col_fin   = entry_done && (row == LASTI);
  assign step_end  = row_fin && (row == LASTI);
  assign otile_end = step_end && t_wrap;
  assign last_step = t_wrap && t3_wrap && (t1 == k1 - CW'(1));

  always_comb begin
    row_nxt = row;
    col_nxt = col;
    if (init) begin
      row_nxt = '0;
      col_nxt = '0;
    end else if (entry_done) begin
      if (col == LASTI) begin
        col_nxt = '0;
        row_nxt = (row == LASTI) ? '0 : row + RW'(1);
      end else begin
        col_nxt = col + RW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0;
      col <= '0;
      t   <= '0;
      t1  <= '0;
      t3  <= '0;
      k1  <= '0;
      k2  <= '0;
      k3  <= '0;
    end else begin
      row <= row_nxt;
      col <= col_nxt;
      if (init) begin
        t  <= '0;
        t1 <= '0;
        t3 <= '0;
        k1 <= cfg_t1;
        k2 <= cfg_t2;
        k3 <= cfg_t3;
      end else if (step_end) begin
        if (t_wrap) begin
          t <= '0;
          if (t3_wrap) begin
            t3 <= '0;
            t1 <= t1 + CW'(1);
          end else begin
            t3 <= t3 + CW'(1);
          end
        end else begin
          t <= t + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tps_slots.sv
// One pending/valid pair per row or column of a scratch-pad bank.
module tps_slots #(
  parameter int N         = 8,
  parameter bit INIT_PEND = 1'b1,
  localparam int RW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          rel_one,
  input  logic [RW-1:0] rel_idx,
  input  logic          rel_all,
  input  logic          ack,
  input  logic [RW-1:0] ack_idx,
  output logic [N-1:0]  pend,
  output logic [N-1:0]  val,
  output logic [N-1:0]  val_nxt
);
  logic [N-1:0] pend_nxt;

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_comb begin
      pend_nxt[i] = pend[i];
      val_nxt[i]  = val[i];
      if (init) begin
        pend_nxt[i] = INIT_PEND;
        val_nxt[i]  = ~INIT_PEND;
      end else begin
        if (rel_all || (rel_one && rel_idx == RW'(i))) begin
          pend_nxt[i] = 1'b1;
          val_nxt[i]  = 1'b0;
        end
        if (ack && ack_idx == RW'(i)) begin
          pend_nxt[i] = 1'b0;
          val_nxt[i]  = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= 1'b0;
        val[i]  <= ~INIT_PEND;
      end else begin
        pend[i] <= pend_nxt[i];
        val[i]  <= val_nxt[i];
      end
    end
  end
endmodule

// File: rtl/tps_arb.sv
// Single-outstanding burst issuer: C write-back, then A, then B; lowest index first.
module tps_arb #(
  parameter int N = 8,
  localparam int RW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  a_pend,
  input  logic [N-1:0]  b_pend,
  input  logic [N-1:0]  c_pend,
  input  logic          burst_ack,
  output logic          burst_req,
  output logic [1:0]    burst_kind,
  output logic [RW-1:0] burst_idx,
  output logic          ack_a,
  output logic          ack_b,
  output logic          ack_c
);
  import tps_pkg::*;

  logic [RW-1:0] a_sel, b_sel, c_sel;
  logic          done_now;

  always_comb begin
    a_sel = '0;
    b_sel = '0;
    c_sel = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (a_pend[i]) a_sel = RW'(i);
      if (b_pend[i]) b_sel = RW'(i);
      if (c_pend[i]) c_sel = RW'(i);
    end
  end

  assign done_now = burst_req && burst_ack;
  assign ack_a = done_now && (burst_kind == KIND_AROW);
  assign ack_b = done_now && (burst_kind == KIND_BCOL);
  assign ack_c = done_now && (burst_kind == KIND_CWB);

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_req  <= 1'b0;
      burst_kind <= KIND_AROW;
      burst_idx  <= '0;
    end else if (burst_req) begin
      if (burst_ack) burst_req <= 1'b0;
    end else if (|c_pend) begin
      burst_req  <= 1'b1;
      burst_kind <= KIND_CWB;
      burst_idx  <= c_sel;
    end else if (|a_pend) begin
      burst_req  <= 1'b1;
      burst_kind <= KIND_AROW;
      burst_idx  <= a_sel;
    end else if (|b_pend) begin
      burst_req  <= 1'b1;
      burst_kind <= KIND_BCOL;
      burst_idx  <= b_sel;
    end
  end
endmodule

// File: rtl/tile_prefetch_sched.sv
module tile_prefetch_sched #(
  parameter int N  = 8,
  parameter int CW = 4,
  localparam int RW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] cfg_t1,
  input  logic [CW-1:0] cfg_t2,
  input  logic [CW-1:0] cfg_t3,
  input  logic          entry_done,
  output logic          may_compute,
  output logic          burst_req,
  output logic [1:0]    burst_kind,
  output logic [RW-1:0] burst_idx,
  input  logic          burst_ack,
  output logic          fill_vld,
  output logic [1:0]    fill_kind,
  output logic [RW-1:0] fill_idx,
  output logic          done
);
  logic [RW-1:0] row, col, row_nxt, col_nxt;
  logic          row_fin, col_fin, step_end, otile_end, last_step;
  logic [N-1:0]  a_pend, a_val, a_val_nxt;
  logic [N-1:0]  b_pend, b_val, b_val_nxt;
  logic [N-1:0]  c_pend, c_val, c_val_nxt;
  logic          ack_a, ack_b, ack_c;
  logic          running, running_nxt, armed, accept, any_pend;
  logic          work_done;

  assign any_pend  = |{a_pend, b_pend, c_pend};
  assign accept    = start && !running && !any_pend && !burst_req;
  assign work_done = entry_done && step_end && last_step;

  always_comb begin
    running_nxt = running;
    if (accept)         running_nxt = 1'b1;
    else if (work_done) running_nxt = 1'b0;
  end

  tps_walker #(.N(N), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .init(accept),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t3(cfg_t3),
    .entry_done(entry_done && running),
    .row(row), .col(col), .row_nxt(row_nxt), .col_nxt(col_nxt),
    .row_fin(row_fin), .col_fin(col_fin), .step_end(step_end),
    .otile_end(otile_end), .last_step(last_step)
  );

  tps_slots #(.N(N), .INIT_PEND(1'b1)) u_aslots (
    .clk(clk), .rst(rst), .init(accept),
    .rel_one(row_fin && !last_step), .rel_idx(row), .rel_all(1'b0),
    .ack(ack_a), .ack_idx(burst_idx),
    .pend(a_pend), .val(a_val), .val_nxt(a_val_nxt)
  );

  tps_slots #(.N(N), .INIT_PEND(1'b1)) u_bslots (
    .clk(clk), .rst(rst), .init(accept),
    .rel_one(col_fin && !last_step), .rel_idx(col), .rel_all(1'b0),
    .ack(ack_b), .ack_idx(burst_idx),
    .pend(b_pend), .val(b_val), .val_nxt(b_val_nxt)
  );

  tps_slots #(.N(N), .INIT_PEND(1'b0)) u_cslots (
    .clk(clk), .rst(rst), .init(accept),
    .rel_one(1'b0), .rel_idx(row), .rel_all(otile_end),
    .ack(ack_c), .ack_idx(burst_idx),
    .pend(c_pend), .val(c_val), .val_nxt(c_val_nxt)
  );

  tps_arb #(.N(N)) u_arb (
    .clk(clk), .rst(rst),
    .a_pend(a_pend), .b_pend(b_pend), .c_pend(c_pend),
    .burst_ack(burst_ack),
    .burst_req(burst_req), .burst_kind(burst_kind), .burst_idx(burst_idx),
    .ack_a(ack_a), .ack_b(ack_b), .ack_c(ack_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      armed       <= 1'b0;
      may_compute <= 1'b0;
      done        <= 1'b0;
      fill_vld    <= 1'b0;
      fill_kind   <= '0;
      fill_idx    <= '0;
    end else begin
      running     <= running_nxt;
      may_compute <= running_nxt && a_val_nxt[row_nxt] && b_val_nxt[col_nxt]
                     && c_val_nxt[row_nxt];
      fill_vld    <= burst_req && burst_ack;
      if (burst_req && burst_ack) begin
        fill_kind <= burst_kind;
        fill_idx  <= burst_idx;
      end
      if (accept) begin
        armed <= 1'b1;
        done  <= 1'b0;
      end else begin
        done <= armed && !running && !any_pend && !burst_req;
      end
    end
  end
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int N = 8,
  localparam int RW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          may_compute,
  input logic          burst_req,
  input logic [1:0]    burst_kind,
  input logic [RW-1:0] burst_idx,
  input logic          burst_ack,
  input logic          fill_vld,
  input logic [1:0]    fill_kind,
  input logic [RW-1:0] fill_idx,
  input logic          done
);
  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (rst)
    burst_req && !burst_ack |=> burst_req && $stable(burst_kind) && $stable(burst_idx));

  p_drop_after_ack_r2: assert property (@(posedge clk) disable iff (rst)
    burst_req && burst_ack |=> !burst_req);

  p_kind_legal_r2: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> burst_kind != 2'd3);

  p_fill_echo_r8: assert property (@(posedge clk) disable iff (rst)
    burst_req && burst_ack |=> fill_vld && fill_kind == $past(burst_kind)
                               && fill_idx == $past(burst_idx));

  p_fill_only_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
    !(burst_req && burst_ack) |=> !fill_vld);

  p_quiet_when_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !burst_req && !may_compute);
endmodule

bind tile_prefetch_sched tps_checker #(.N(N)) u_tps_chk (
  .clk(clk), .rst(rst), .may_compute(may_compute),
  .burst_req(burst_req), .burst_kind(burst_kind), .burst_idx(burst_idx),
  .burst_ack(burst_ack), .fill_vld(fill_vld), .fill_kind(fill_kind),
  .fill_idx(fill_idx), .done(done)
);

// File: tb/tile_prefetch_sched_bench.sv
`timescale 1ns/1ps
module tile_prefetch_sched_bench;
  localparam int N  = 4;
  localparam int CW = 4;
  localparam int RW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] cfg_t1 = '0, cfg_t2 = '0, cfg_t3 = '0;
  logic          entry_done = 1'b0;
  logic          may_compute, burst_req, fill_vld, done;
  logic [1:0]    burst_kind, fill_kind;
  logic [RW-1:0] burst_idx, fill_idx;
  logic          burst_ack = 1'b0;

  always #4 clk = ~clk;

  tile_prefetch_sched #(.N(N), .CW(CW)) u_tile_prefetch_sched (
    .clk(clk), .rst(rst), .start(start),
    .cfg_t1(cfg_t1), .cfg_t2(cfg_t2), .cfg_t3(cfg_t3),
    .entry_done(entry_done), .may_compute(may_compute),
    .burst_req(burst_req), .burst_kind(burst_kind), .burst_idx(burst_idx),
    .burst_ack(burst_ack), .fill_vld(fill_vld), .fill_kind(fill_kind),
    .fill_idx(fill_idx), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench model of the loop nest and slot contents
  int k1, k2, k3, lat, gap;
  int br, bc, bt, bt1, bt3, gcnt, mcnt;
  int n_a, n_b, n_c;
  bit run_m, nostall_en, nostall_pend;
  logic [N-1:0] a_have, a_free, b_have, b_free, c_clean, c_wbok;
  logic [1:0]    cap_kind;
  logic [RW-1:0] cap_idx;

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  task automatic advance_model();
    bit last;
    last = (bt == k2 - 1) && (bt3 == k3 - 1) && (bt1 == k1 - 1);
    if (bc == N - 1 && !last) begin a_have[br] = 1'b0; a_free[br] = 1'b1; end
    if (br == N - 1 && !last) begin b_have[bc] = 1'b0; b_free[bc] = 1'b1; end
    if (br == N - 1 && bc == N - 1) begin
      if (bt == k2 - 1) begin
        c_clean = '0;
        c_wbok  = '1;
      end else if (nostall_en) begin
        nostall_pend = 1'b1;
      end
      if (last) run_m = 1'b0;
      if (bt == k2 - 1) begin
        bt = 0;
        if (bt3 == k3 - 1) begin bt3 = 0; bt1++; end else bt3++;
      end else bt++;
    end
    if (bc == N - 1) begin bc = 0; br = (br == N - 1) ? 0 : br + 1; end
    else bc++;
  endtask

  // single process: checks first, then memory, then compute, each negedge
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (!rst) begin
        if (run_m) begin
          checks++;
          if (may_compute !== (a_have[br] && b_have[bc] && c_clean[br]))
            fail("R6", "may_compute", int'(may_compute),
                 int'(a_have[br] && b_have[bc] && c_clean[br]));
        end
        if (nostall_pend) begin
          nostall_pend = 1'b0;
          chk("R9", "may_compute after pair boundary", int'(may_compute), 1);
        end
        // memory model
        if (burst_ack) begin
          burst_ack = 1'b0;
          mcnt = 0;
          chk("R2", "burst_req after ack", int'(burst_req), 0);
          checks++;
          if (!(fill_vld && fill_kind == cap_kind && fill_idx == cap_idx))
            fail("R8", "fill pulse kind", int'(fill_kind), int'(cap_kind));
        end else if (burst_req) begin
          if (mcnt == 0) begin
            cap_kind = burst_kind;
            cap_idx  = burst_idx;
            checks++;
            case (burst_kind)
              2'd0: if (!a_free[burst_idx]) fail("R3", "A row not yet released", int'(burst_idx), -1);
              2'd1: if (!b_free[burst_idx]) fail("R4", "B column not yet released", int'(burst_idx), -1);
              2'd2: if (!c_wbok[burst_idx]) fail("R5", "C write-back not due", int'(burst_idx), -1);
              default: fail("R2", "burst_kind", int'(burst_kind), 0);
            endcase
          end else begin
            checks++;
            if (burst_kind != cap_kind || burst_idx != cap_idx)
              fail("R2", "request changed before ack", int'(burst_idx), int'(cap_idx));
          end
          mcnt++;
          if (mcnt >= lat) begin
            burst_ack = 1'b1;
            case (cap_kind)
              2'd0: begin a_have[cap_idx] = 1'b1; a_free[cap_idx] = 1'b0; n_a++; end
              2'd1: begin b_have[cap_idx] = 1'b1; b_free[cap_idx] = 1'b0; n_b++; end
              default: begin c_clean[cap_idx] = 1'b1; c_wbok[cap_idx] = 1'b0; n_c++; end
            endcase
          end
        end
        // compute model
        if (run_m && may_compute && gcnt >= gap) begin
          entry_done = 1'b1;
          gcnt = 0;
          advance_model();
        end else begin
          entry_done = 1'b0;
          if (may_compute) gcnt++;
        end
      end
    end
  end

  task automatic run_case(input int t1, input int t2, input int t3,
                          input int l, input int g, input bit nostall, input string tag);
    int waited;
    k1 = t1; k2 = t2; k3 = t3; lat = l; gap = g; nostall_en = nostall;
    br = 0; bc = 0; bt = 0; bt1 = 0; bt3 = 0; gcnt = 0; mcnt = 0;
    n_a = 0; n_b = 0; n_c = 0;
    a_have = '0; a_free = '1; b_have = '0; b_free = '1;
    c_clean = '1; c_wbok = '0;
    @(negedge clk);
    cfg_t1 = CW'(t1); cfg_t2 = CW'(t2); cfg_t3 = CW'(t3);
    start = 1'b1;
    run_m = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", {tag, " done cleared by start"}, int'(done), 0);
    waited = 0;
    while (!done && waited < 40000) begin
      @(negedge clk);
      waited++;
    end
    chk("R10", {tag, " done reached"}, int'(done), 1);
    chk("R6", {tag, " all entries computed"}, int'(run_m), 0);
    chk("R7", {tag, " A row loads"}, n_a, N * t1 * t2 * t3);
    chk("R7", {tag, " B column loads"}, n_b, N * t1 * t2 * t3);
    chk("R5", {tag, " C write-backs"}, n_c, N * t1 * t3);
    repeat (3) @(negedge clk);
    chk("R10", {tag, " done held"}, int'(done), 1);
    chk("R10", {tag, " no request while done"}, int'(burst_req), 0);
    chk("R10", {tag, " may_compute low while done"}, int'(may_compute), 0);
  endtask

  task automatic test_reset();
    chk("R1", "burst_req after reset", int'(burst_req), 0);
    chk("R1", "may_compute after reset", int'(may_compute), 0);
    chk("R1", "fill_vld after reset", int'(fill_vld), 0);
    chk("R1", "done after reset", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    run_case(1, 1, 1, 2, 0, 1'b0, "single");
    run_case(2, 3, 2, 1, 1, 1'b0, "grid");
    run_case(1, 4, 1, 1, 4, 1'b1, "overlap");
    run_case(2, 1, 3, 9, 0, 1'b0, "slowmem");
    run_case(1, 3, 2, 1, 6, 1'b1, "overlap2");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule